// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block moves data one unit at a time on behalf of peripherals. Each channel keeps a source address, a destination address, a transfer counter and a control word. A typical setup reads a peripheral's receive-data register at a fixed address and writes each byte into memory at an address that rises by one. A shared operation register gates all channels.

Each transfer is started by a request level from the peripheral. The engine takes the bus, reads one unit from the source into an internal latch, and writes it to the destination. It then gives the bus back and pulses an acknowledge to the requester, so at most one transfer happens per bus tenure. When a channel's counter reaches zero the channel raises an end flag and stops. The flag drives that channel's interrupt if the interrupt is enabled. When several channels want the bus at once, the lowest-numbered channel wins.

Top module: `dma2_cs_engine`

## Requirements
- R1: After reset, mem_rd, mem_wr, every dack bit and every irq bit are 0, and no transfer starts until a channel and the operation register are programmed.
- R2: Each transfer is one read cycle at the channel's source address, then one write cycle at its destination address. The write carries the unit captured by that read.
- R3: Control bit 3 makes the source address advance by DW/8 (1 for bytes) after each transfer, and control bit 4 does the same for the destination. When a bit is 0, that address stays fixed.
- R4: A channel performs exactly the programmed count of transfers. After that, further requests get no acknowledge and cause no bus cycles.
- R5: After each completed write, the next cycle has mem_rd and mem_wr both 0. In that cycle the served channel's dack bit is 1 for exactly one cycle.
- R6: When several channels are eligible in the same cycle, the lowest-numbered one is served first. With both channels requesting continuously, channel 0 completes all its transfers before channel 1 starts.
- R7: Bit 0 of the operation register (cfg_sel 4) is the master enable. While it is 0, no transfer starts. Setting it lets pending requests proceed.
- R8: The end flag of a channel stays set until software writes its control word with bit 0 (enable) set, or with bit 1 (end flag) cleared. irq[i] is the end flag ANDed with control bit 2.
- R9: A read or write cycle is held, with a stable address, until mem_ready is sampled high.
- R10: Configuration writes select a register with cfg_sel: 0 source, 1 destination, 2 count, 3 control, 4 operation. cfg_ch picks the channel for selects 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | IW | Channel index for the write |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Write data |
| dreq | input | NCH | Per-channel request level |
| dack | output | NCH | Per-channel one-cycle acknowledge |
| irq | output | NCH | Per-channel end-of-transfer interrupt |
| mem_addr | output | AW | Bus address |
| mem_rd | output | 1 | Read cycle active |
| mem_wr | output | 1 | Write cycle active |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Cycle completes when high |

## Verification
The main tests are described by how their address patterns reveal faults:
- Peripheral-to-memory with a fixed source and a rising destination. The rising destination shows each transferred byte at a distinct address, so a skipped or repeated transfer is visible.
- Memory-to-memory with both addresses rising. This separates the source-increment path from the destination-increment path.
- Both addresses fixed. Only the last byte lands, and the next address stays untouched.

The remaining tests check arbitration, gating and flow control:
- Simultaneous requests on both channels. The order of the write addresses shows the priority.
- A master-disabled phase. No acknowledge should appear until the enable is set.
- Wait states inserted on every other cycle. These show whether cycles are held and whether the bus is released between transfers.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
   typedef enum logic [1:0] {XS_IDLE, XS_READ, XS_WRITE, XS_DONE} xfer_state_t;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_CNT  = 3'd2;
   localparam logic [2:0] SEL_CTRL = 3'd3;
   localparam logic [2:0] SEL_OPER = 3'd4;

   localparam int CB_EN   = 0;
   localparam int CB_END  = 1;
   localparam int CB_IE   = 2;
   localparam int CB_SINC = 3;
   localparam int CB_DINC = 4;
endpackage

// File: rtl/dma2_chan_regs.sv
module dma2_chan_regs
   import dma2_pkg::*;
#(
   parameter int AW   = 16,
   parameter int CW   = 16,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic          step,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic          ch_en,
   output logic          ch_end,
   output logic          cnt_nz,
   output logic          irq
);
   localparam logic [AW-1:0] INC = AW'(STEP);

   logic [CW-1:0] cnt_q;
   logic          ie_q, sinc_q, dinc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_addr <= '0;
         dst_addr <= '0;
         cnt_q    <= '0;
         ch_en    <= 1'b0;
         ch_end   <= 1'b0;
         ie_q     <= 1'b0;
         sinc_q   <= 1'b0;
         dinc_q   <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_SRC:  src_addr <= wr_data;
            SEL_DST:  dst_addr <= wr_data;
            SEL_CNT:  cnt_q    <= wr_data[CW-1:0];
            SEL_CTRL: begin
               ch_en  <= wr_data[CB_EN];
               ie_q   <= wr_data[CB_IE];
               sinc_q <= wr_data[CB_SINC];
               dinc_q <= wr_data[CB_DINC];
               ch_end <= wr_data[CB_EN] ? 1'b0 : (ch_end & wr_data[CB_END]);
            end
            default: ;
         endcase
      end else if (step) begin
         if (sinc_q) src_addr <= src_addr + INC;
         if (dinc_q) dst_addr <= dst_addr + INC;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) ch_end <= 1'b1;
      end
   end

   assign cnt_nz = (cnt_q != '0);
   assign irq    = ch_end & ie_q;

   AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_end && !(wr_en && wr_sel == SEL_CTRL)) |=> ch_end); // R8
   AST_STEP_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt_q != '0 && !ch_end)); // R4
endmodule

// File: rtl/dma2_fixed_arb.sv
module dma2_fixed_arb #(
   parameter int N  = 2,
   parameter int IW = 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic          gnt_any,
   output logic [IW-1:0] gnt_idx
);
   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt     = '0;
            gnt[i]  = 1'b1;
            gnt_idx = IW'(i);
         end
      end
      gnt_any = |req;
   end
endmodule

// File: rtl/dma2_xfer_fsm.sv
module dma2_xfer_fsm
   import dma2_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int N  = 2,
   parameter int IW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] start_idx,
   input  logic [AW-1:0] start_src,
   input  logic [AW-1:0] start_dst,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   output logic [N-1:0]  step,
   output logic          busy
);
   xfer_state_t   state_q;
   logic [IW-1:0] cur_q;
   logic [AW-1:0] src_q, dst_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cur_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            XS_IDLE: if (start) begin
               cur_q   <= start_idx;
               src_q   <= start_src;
               dst_q   <= start_dst;
               state_q <= XS_READ;
            end
            XS_READ: if (mem_ready) begin
               data_q  <= mem_rdata;
               state_q <= XS_WRITE;
            end
            XS_WRITE: if (mem_ready) state_q <= XS_DONE;
            default:  state_q <= XS_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd    = (state_q == XS_READ);
      mem_wr    = (state_q == XS_WRITE);
      mem_addr  = (state_q == XS_WRITE) ? dst_q : src_q;
      mem_wdata = data_q;
      busy      = (state_q != XS_IDLE);
      for (int i = 0; i < N; i++)
         step[i] = (state_q == XS_DONE) && (cur_q == IW'(i));
   end

   AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=> ((mem_rd || mem_wr) && $stable(mem_addr))); // R9
   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_ready) |=> mem_wr); // R2
   AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_ready) |=> (!mem_rd && !mem_wr && step != '0)); // R5
endmodule

// File: rtl/dma2_cs_engine.sv
module dma2_cs_engine
   import dma2_pkg::*;
#(
   parameter int NCH = 2,
   parameter int AW  = 16,
   parameter int DW  = 8,
   parameter int CW  = 16,
   localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [IW-1:0]  cfg_ch,
   input  logic [2:0]     cfg_sel,
   input  logic [AW-1:0]  cfg_wdata,
   input  logic [NCH-1:0] dreq,
   output logic [NCH-1:0] dack,
   output logic [NCH-1:0] irq,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   input  logic           mem_ready
);
   localparam int STEP = DW / 8;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("NCH out of range");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("DW must be a whole number of bytes");
   end
   if (CW < 1 || CW > AW) begin : g_bad_cw
      $error("CW must fit in the write data");
   end

   logic           master_en;
   logic [NCH-1:0] ch_en, ch_end, cnt_nz, step, elig, gnt;
   logic [AW-1:0]  src_v [NCH];
   logic [AW-1:0]  dst_v [NCH];
   logic           gnt_any, busy;
   logic [IW-1:0]  gnt_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               master_en <= 1'b0;
      else if (cfg_we && cfg_sel == SEL_OPER)   master_en <= cfg_wdata[0];
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma2_chan_regs #(.AW(AW), .CW(CW), .STEP(STEP)) regs_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && cfg_sel != SEL_OPER && cfg_ch == IW'(i)),
         .wr_sel   (cfg_sel),
         .wr_data  (cfg_wdata),
         .step     (step[i]),
         .src_addr (src_v[i]),
         .dst_addr (dst_v[i]),
         .ch_en    (ch_en[i]),
         .ch_end   (ch_end[i]),
         .cnt_nz   (cnt_nz[i]),
         .irq      (irq[i])
      );
      assign elig[i] = master_en & ch_en[i] & ~ch_end[i] & cnt_nz[i] & dreq[i] & ~busy;
   end

   dma2_fixed_arb #(.N(NCH), .IW(IW)) arb_i (
      .req     (elig),
      .gnt     (gnt),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
   );

   dma2_xfer_fsm #(.AW(AW), .DW(DW), .N(NCH), .IW(IW)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (gnt_any),
      .start_idx (gnt_idx),
      .start_src (src_v[gnt_idx]),
      .start_dst (dst_v[gnt_idx]),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .step      (step),
      .busy      (busy)
   );

   assign dack = step;

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R6
   AST_CH0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      elig[0] |-> gnt[0]); // R6
   AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_en && !busy) |=> !mem_rd); // R7
   AST_DACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (dack != '0) |=> (dack == '0)); // R5
endmodule

// File: tb/dma2_cs_engine_tb.sv
module dma2_cs_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] SEED0 = 8'h30;
   localparam logic [7:0] SEED1 = 8'h70;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [0:0]  cfg_ch = '0;
   logic [2:0]  cfg_sel = '0;
   logic [15:0] cfg_wdata = '0;
   logic [1:0]  dreq, dack, irq;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;
   logic        wait_mode = 1'b0;

   int nchk = 0, nfail = 0;
   int served [2];
   int target [2];
   int wcnt;
   logic [15:0] wlog [64];
   logic [7:0]  mem [256];
   bit finished = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma2_cs_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
      .irq(irq), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // peripheral and memory models
   initial begin
      target[0] = 0;
      target[1] = 0;
   end
   always_comb begin
      dreq[0] = served[0] < target[0];
      dreq[1] = served[1] < target[1];
   end
   always_comb begin
      if (mem_addr[15:8] == 8'hFF)
         mem_rdata = (mem_addr[0] ? SEED1 + 8'(served[1]) : SEED0 + 8'(served[0]));
      else if (mem_addr[7:4] == 4'h1)
         mem_rdata = 8'hA0 + {4'h0, mem_addr[3:0]};
      else
         mem_rdata = mem[mem_addr[7:0]];
   end
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
         served[0] <= 0;
         served[1] <= 0;
         wcnt <= 0;
      end else begin
         if (mem_wr && mem_ready) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wlog[wcnt % 64] <= mem_addr;
            wcnt <= wcnt + 1;
         end
         if (dack[0]) served[0] <= served[0] + 1;
         if (dack[1]) served[1] <= served[1] + 1;
      end
   end
   always @(negedge clk) mem_ready <= wait_mode ? ~mem_ready : 1'b1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle monitor, sampled after the falling edge
   logic p_rd = 0, p_wr = 0, p_rdy = 0;
   logic [15:0] p_addr = '0;
   logic [1:0]  p_dack = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (p_wr && p_rdy) chk(!mem_rd && !mem_wr && dack != 0, "R5 release/ack after write", {mem_rd, mem_wr, dack}, 32'h1);
         if ((p_rd || p_wr) && !p_rdy) chk((mem_rd == p_rd) && (mem_wr == p_wr) && mem_addr == p_addr, "R9 cycle held", mem_addr, p_addr);
         for (int i = 0; i < 2; i++)
            if (p_dack[i]) chk(!dack[i], "R5 dack single cycle", dack, 0);
      end
      p_rd = mem_rd; p_wr = mem_wr; p_rdy = mem_ready; p_addr = mem_addr; p_dack = dack;
   end

   task automatic cfg(input int ch, input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = ch[0:0]; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prog(input int ch, input logic [15:0] s, input logic [15:0] d, input logic [15:0] n, input logic [15:0] c);
      cfg(ch, 3'd0, s);
      cfg(ch, 3'd1, d);
      cfg(ch, 3'd2, n);
      cfg(ch, 3'd3, c);
   endtask

   task automatic wait_irq(input int ch, input string tag);
      int k;
      k = 0;
      while (!irq[ch] && k < 3000) begin
         @(negedge clk);
         k++;
      end
      chk(irq[ch] == 1'b1, tag, irq, 32'h1 << ch);
   endtask

   task automatic t_reset();
      chk(!mem_rd && !mem_wr, "R1 bus idle after reset", {mem_rd, mem_wr}, 0);
      chk(dack == 0 && irq == 0, "R1 dack/irq low after reset", {dack, irq}, 0);
      target[0] = 1;
      repeat (10) @(negedge clk);
      chk(served[0] == 0, "R1 no transfer unprogrammed", served[0], 0);
      target[0] = 0;
   endtask

   task automatic t_periph_to_mem();
      int b;
      b = served[1];
      cfg(0, 3'd4, 16'h0001);
      prog(1, 16'hFF01, 16'h0040, 16'd8, 16'h0015);   // R10 register selects
      target[1] = b + 8;
      wait_irq(1, "R8 irq on end of count");
      for (int k = 0; k < 8; k++)
         chk(mem[8'h40 + k] == SEED1 + 8'(b + k), "R2 R3 byte at rising dst", mem[8'h40 + k], SEED1 + 8'(b + k));
      chk(served[1] == b + 8, "R4 exact transfer count", served[1], b + 8);
      target[1] = b + 11;
      repeat (40) @(negedge clk);
      chk(served[1] == b + 8, "R4 no ack after count", served[1], b + 8);
      chk(mem[8'h48] == 8'h00, "R4 no write after count", mem[8'h48], 0);
      chk(irq[1] == 1'b1, "R8 end flag held", irq, 2);
      target[1] = served[1];
      cfg(1, 3'd3, 16'h0004);
      chk(irq[1] == 1'b0, "R8 flag cleared by write", irq, 0);
   endtask

   task automatic t_master_off();
      int b;
      b = served[0];
      cfg(0, 3'd4, 16'h0000);
      prog(0, 16'hFF00, 16'h00A0, 16'd2, 16'h0015);
      target[0] = b + 2;
      repeat (40) @(negedge clk);
      chk(served[0] == b, "R7 no ack while disabled", served[0], b);
      chk(mem[8'hA0] == 8'h00, "R7 no write while disabled", mem[8'hA0], 0);
      cfg(0, 3'd4, 16'h0001);
      wait_irq(0, "R7 runs after enable");
      chk(mem[8'hA1] == SEED0 + 8'(b + 1), "R7 data after enable", mem[8'hA1], SEED0 + 8'(b + 1));
   endtask

   task automatic t_priority();
      int w0, b0, b1;
      b0 = served[0]; b1 = served[1];
      prog(0, 16'hFF00, 16'h0060, 16'd4, 16'h0015);
      prog(1, 16'hFF01, 16'h0080, 16'd4, 16'h0015);
      w0 = wcnt;
      @(negedge clk);
      target[0] = b0 + 4;
      target[1] = b1 + 4;
      wait_irq(0, "R6 ch0 done");
      wait_irq(1, "R6 ch1 done");
      chk(wlog[w0 % 64] == 16'h0060, "R6 ch0 served first", wlog[w0 % 64], 16'h0060);
      chk(wlog[(w0 + 3) % 64] == 16'h0063, "R6 ch0 runs to end", wlog[(w0 + 3) % 64], 16'h0063);
      chk(wlog[(w0 + 4) % 64] == 16'h0080, "R6 ch1 after ch0", wlog[(w0 + 4) % 64], 16'h0080);
   endtask

   task automatic t_modes_waits();
      int b;
      wait_mode = 1'b1;
      prog(0, 16'h0010, 16'h0020, 16'd4, 16'h001D);
      target[0] = served[0] + 4;
      wait_irq(0, "R9 copy completes with waits");
      for (int k = 0; k < 4; k++)
         chk(mem[8'h20 + k] == 8'hA0 + 8'(k), "R3 R9 rising src and dst", mem[8'h20 + k], 8'hA0 + 8'(k));
      b = served[1];
      prog(1, 16'hFF01, 16'h0030, 16'd3, 16'h0005);
      target[1] = b + 3;
      wait_irq(1, "R3 fixed dst completes");
      chk(mem[8'h30] == SEED1 + 8'(b + 2), "R3 fixed dst holds last", mem[8'h30], SEED1 + 8'(b + 2));
      chk(mem[8'h31] == 8'h00, "R3 fixed dst no advance", mem[8'h31], 0);
      wait_mode = 1'b0;
   endtask

   task automatic t_reenable();
      cfg(1, 3'd3, 16'h0017);
      chk(irq[1] == 1'b0, "R8 re-enable clears flag", irq, 0);
      cfg(0, 3'd3, 16'h0006);
      chk(irq[0] == 1'b1, "R8 write with flag bit keeps it", irq, 1);
      cfg(0, 3'd3, 16'h0004);
      chk(irq[0] == 1'b0, "R8 clear flag ch0", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_periph_to_mem();
      t_master_off();
      t_priority();
      t_modes_waits();
      t_reenable();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule